// File: doc/BRIEF.md
# Passive Pass-Through Region Responder

This block sits on the add-on side of a host-bus bridge whose pass-through channel runs in passive mode. When the bridge decodes a host cycle that targets one of four pass-through regions, it pulls an active-low attention strobe. While that strobe is low, the bridge also presents a region number, active-low byte enables, a write flag and a burst flag. The responder samples these qualifiers when the cycle starts. It then asks the bridge for the transaction address by pulling an address-request strobe for one cycle, and reads the address off the shared 32-bit data bus.

Each region is backed by a small local store of DWORDs, indexed by address bits [5:2]. On a write, the responder takes the bridge's data from the bus and updates only the enabled bytes. On a read, it drives the stored word onto the bus, with the disabled byte lanes forced to zero. Every DWORD is acknowledged with a one-cycle active-low ready pulse. In a burst, the local index advances after each pulse, and the cycle ends when the bridge lets go of attention.

Top module: `passthru_responder`

## Requirements
- R1: After reset, ready and address-request are both high (inactive) and the data bus is released.
- R2: On the first clock edge that sees attention low while idle, address-request goes low for exactly one cycle. At the end of that cycle, bits [5:2] of the data bus are taken as the starting DWORD index, and all other address bits are ignored.
- R3: Ready goes low for exactly one cycle per DWORD and only while attention is low.
- R4: Region code 0 to 3 selects one of four independent stores, so a write to one region leaves the same index in the other regions unchanged.
- R5: On a write, byte-enable bit b (active low) guards data bus bits [8b+7:8b]. Only enabled bytes of the addressed DWORD are updated, at the clock edge that ends the ready cycle.
- R6: On a read, the enabled bytes of the addressed DWORD are driven on the bus during the data phase and the ready cycle, and disabled byte lanes are driven as zero.
- R7: The responder drives the data bus only during read data and ready cycles. It leaves the bus released while address-request is low and for the whole of a write.
- R8: With the burst flag set, the index increments modulo 16 after each ready pulse. The burst ends without a further ready pulse when attention is high in the cycle after a ready pulse.
- R9: With the burst flag clear, exactly one DWORD is transferred, and the responder returns to idle after the ready pulse.
- R10: Ready is never low in a cycle in which address-request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Add-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_n | input | 1 | Active-low attention from the bridge |
| region | input | 2 | Region code of the current cycle |
| byte_en_n | input | 4 | Active-low byte enables |
| is_write | input | 1 | High for a write cycle, low for a read |
| burst | input | 1 | High when the cycle is a burst |
| ready_n | output | 1 | Active-low per-DWORD completion strobe |
| addr_req_n | output | 1 | Active-low request for the bridge to drive the address |
| dq | inout | 32 | Shared address/data bus |

## Verification
Two of the block's functions can fall in the same cycle: the bridge releasing attention after a burst's final DWORD, and the responder re-entering its data phase for the next beat. The bench provokes this by lifting attention on the falling edge straight after the last ready pulse of every burst. It judges the outcome on two counts. Ready must stay high for the following cycles. A later read of the index one past the final beat must return the value it held before the burst, which shows that no extra beat was acknowledged or written. A second overlap is the address fetch against the read data drive, and the bridge model checks that ready never coincides with an address request.

// File: rtl/passthru_responder.sv
module passthru_responder #(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int NREG   = 4,
  parameter int IDX_LO = 2,
  localparam int BYTES = DW / 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int RW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attn_n,
  input  logic [RW-1:0]    region,
  input  logic [BYTES-1:0] byte_en_n,
  input  logic             is_write,
  input  logic             burst,
  output logic             ready_n,
  output logic             addr_req_n,
  inout  wire  [DW-1:0]    dq
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_RDY} state_t;

  state_t           state;
  logic [RW-1:0]    region_q;
  logic [BYTES-1:0] be_q;
  logic             wr_q;
  logic             burst_q;
  logic [IW-1:0]    idx;
  logic [DW-1:0]    store [NREG*DEPTH];
  logic [DW-1:0]    rd_word;
  logic             drive;

  wire [RW+IW-1:0] slot = {region_q, idx};

  assign addr_req_n = (state != S_ADDR);
  assign ready_n    = (state != S_RDY);
  assign drive      = !wr_q && (state == S_DATA || state == S_RDY);
  assign dq         = drive ? rd_word : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      region_q <= '0;
      be_q     <= '1;
      wr_q     <= 1'b0;
      burst_q  <= 1'b0;
      idx      <= '0;
    end else begin
      case (state)
        S_IDLE: if (!attn_n) begin
          region_q <= region;
          be_q     <= byte_en_n;
          wr_q     <= is_write;
          burst_q  <= burst;
          state    <= S_ADDR;
        end
        S_ADDR: begin
          idx   <= dq[IDX_LO +: IW];
          state <= S_DATA;
        end
        S_DATA: state <= attn_n ? S_IDLE : S_RDY;
        S_RDY: begin
          if (burst_q) begin
            idx   <= idx + 1'b1;
            state <= S_DATA;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_RDY && wr_q) begin
      for (int b = 0; b < BYTES; b++)
        if (!be_q[b]) store[slot][8*b +: 8] <= dq[8*b +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      rd_word[8*b +: 8] = be_q[b] ? 8'h00 : store[slot][8*b +: 8];
  end

  AST_READY_IN_ATTN: assert property (@(posedge clk) disable iff (!rst_n) !ready_n |-> !attn_n); // R3
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !ready_n |=> ready_n); // R3
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !addr_req_n |=> addr_req_n); // R2
  AST_BUS_FREE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !addr_req_n |-> !drive); // R7
  AST_ADDR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !addr_req_n |-> ready_n); // R10
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (!ready_n && !burst_q) |=> state == S_IDLE); // R9
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!ready_n && burst_q) |=> idx == IW'($past(idx) + 1'b1)); // R8

endmodule

// File: tb/passthru_responder_bench.sv
`timescale 1ns/1ps
module passthru_responder_bench;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        attn_n = 1;
  logic [1:0]  region = 0;
  logic [3:0]  byte_en_n = 4'hF;
  logic        is_write = 0;
  logic        burst = 0;
  logic        ready_n;
  logic        addr_req_n;
  wire  [31:0] dq;
  logic [31:0] addr_r = 0;
  logic [31:0] wdata_r = 0;

  int total = 0;
  int fails = 0;
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  assign dq = !addr_req_n ? addr_r :
              (is_write && !attn_n && !ready_n) ? wdata_r : 32'bz;

  passthru_responder u_passthru_responder (
    .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .region(region),
    .byte_en_n(byte_en_n), .is_write(is_write), .burst(burst),
    .ready_n(ready_n), .addr_req_n(addr_req_n), .dq(dq)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [1:0] rg, input logic [3:0] be, input logic w,
                           input logic bst, input logic [31:0] a, input int beats,
                           input logic [31:0] seed);
    int addr_cycles = 0;
    @(negedge clk);
    attn_n = 0; region = rg; byte_en_n = be; is_write = w; burst = bst;
    addr_r = a; wdata_r = seed;
    for (int k = 0; k < beats; k++) begin
      int slot = rg * 16 + ((a[5:2] + k) % 16);
      logic got = 0;
      for (int t = 0; t < 40 && !got; t++) begin
        @(posedge clk); #1;
        if (!addr_req_n) begin
          addr_cycles++;
          check(ready_n == 1'b1, "R10 ready during address request", {31'b0, ready_n}, 32'h1);
        end
        if (!ready_n) got = 1;
      end
      check(got, "R3 ready pulse per DWORD", {31'b0, got}, 32'h1);
      if (w) begin
        for (int b = 0; b < 4; b++)
          if (!be[b]) model[slot][8*b +: 8] = wdata_r[8*b +: 8];
      end else begin
        logic [31:0] exp;
        for (int b = 0; b < 4; b++) exp[8*b +: 8] = be[b] ? 8'h00 : model[slot][8*b +: 8];
        check(dq === exp, "R6 read data and lane masking", dq, exp);
      end
      @(posedge clk);
      @(negedge clk);
      wdata_r = seed + (k + 1) * 32'h01010101;
    end
    attn_n = 1; is_write = 0; burst = 0;
    check(addr_cycles == 1, "R2 single address request", addr_cycles, 1);
    for (int t = 0; t < 3; t++) begin
      @(posedge clk); #1;
      check(ready_n && addr_req_n, "R9 R8 quiet after release", {30'b0, ready_n, addr_req_n}, 32'h3);
    end
  endtask

  task automatic t_reset;
    #1;
    check(ready_n == 1'b1, "R1 ready idle", {31'b0, ready_n}, 32'h1);
    check(addr_req_n == 1'b1, "R1 address request idle", {31'b0, addr_req_n}, 32'h1);
  endtask

  task automatic t_single;
    run_cycle(2'd0, 4'h0, 1, 0, 32'h0000_0014, 1, 32'hDEAD_BEEF);
    run_cycle(2'd0, 4'h0, 0, 0, 32'h0000_0014, 1, 0);
  endtask

  task automatic t_byte_lanes;
    run_cycle(2'd0, 4'b1010, 1, 0, 32'h0000_0014, 1, 32'h1122_3344); // R5
    run_cycle(2'd0, 4'h0, 0, 0, 32'h0000_0014, 1, 0);
    run_cycle(2'd0, 4'b0110, 0, 0, 32'h0000_0014, 1, 0); // R6
  endtask

  task automatic t_regions;
    for (int r = 0; r < 4; r++)
      run_cycle(r[1:0], 4'h0, 1, 0, 32'h0000_000C, 1, 32'hA000_0000 + r); // R4
    for (int r = 0; r < 4; r++)
      run_cycle(r[1:0], 4'h0, 0, 0, 32'h0000_000C, 1, 0);
  endtask

  task automatic t_burst;
    run_cycle(2'd1, 4'h0, 1, 0, 32'h0000_0008, 1, 32'h5555_AAAA);
    run_cycle(2'd2, 4'h0, 1, 0, 32'h0000_0008, 1, 32'h0BAD_F00D);
    run_cycle(2'd2, 4'h0, 1, 1, 32'h0000_0038, 4, 32'h1000_0001); // R8 wrap 14,15,0,1
    run_cycle(2'd2, 4'h0, 0, 1, 32'h0000_0038, 5, 0); // R8 read incl. untouched idx 2
    run_cycle(2'd1, 4'h0, 0, 1, 32'h0000_0008, 1, 0); // R4 neighbour untouched
  endtask

  task automatic t_high_addr;
    run_cycle(2'd3, 4'h0, 1, 0, 32'hFFFF_FFC4, 1, 32'hC0FF_EE00); // R2 idx 1
    run_cycle(2'd3, 4'h0, 0, 0, 32'h0000_0004, 1, 0);
    run_cycle(2'd3, 4'h0, 1, 0, 32'h0000_0000, 1, 32'h7777_0000); // R7 bridge data taken intact
    run_cycle(2'd3, 4'h0, 0, 0, 32'h8000_0000, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'h0;
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    // prime every slot so reads never depend on power-up contents
    for (int r = 0; r < 4; r++)
      run_cycle(r[1:0], 4'h0, 1, 1, 32'h0, 16, 32'h0000_0000);
    t_single;
    t_byte_lanes;
    t_regions;
    t_burst;
    t_high_addr;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule